// File: doc/BRIEF.md
# Host I/O Address Decoder

This block turns ISA-style host I/O cycles into one-hot select strobes for the functions of an I/O controller. It watches an 11-bit I/O address together with active-low read and write strobes. It captures the address on the leading edge of a strobe and holds that copy for the rest of the cycle. It then compares the held address, all eleven bits, against a configuration index/data port pair and against a small set of programmable function windows. The matching select line stays high only while the strobe is active.

An address-enable input marks DMA cycles, and during those cycles every select is suppressed. An optional active-low external chip select can be made part of every decode, so that an outside decoder can qualify the address bits above A10. A strap input is sampled while reset is held and is frozen when reset is released. The strap places the configuration index port at one of two bases. The function window bases are written through a simple write port. Reset leaves them unchanged, so a programmed map survives a reset.

Top module: `hostio_decoder`

## Requirements
- R1: The address is captured in the clock cycle in which read or write first goes low. While that strobe stays low, the selects and `addr_lat` follow the captured address and ignore any later change on `addr`.
- R2: Every decode compares all eleven address bits, so an address that differs from a match only in A10 selects nothing.
- R3: While `aen` is high, no select output asserts.
- R4: When `ext_cs_en` is 1, a decode needs `cs_n` low. When `ext_cs_en` is 0, `cs_n` has no effect.
- R5: `strap` is sampled on every clock while `rst` is high and is held after `rst` falls. A value of 0 puts the index port at 0x3F0 and a value of 1 puts it at 0x370. A change on `strap` after reset has no effect.
- R6: Reset does not clear the programmed window bases.
- R7: The configuration data port is the index port address plus one. An access to the index port raises only `cfg_idx_sel`, and an access to the data port raises only `cfg_dat_sel`.
- R8: A window whose programmed base is zero never decodes.
- R9: At most one select is high. The configuration ports take priority over the windows, and among overlapping windows the lowest-numbered one wins. `fn_sel` bit i belongs to window i.
- R10: Selects are high only while a strobe is low and `rst` is low. They fall in the same cycle that the strobe returns high.
- R11: Each window covers 8 aligned bytes, and the low 3 bits of a base are ignored. A clock edge with `prog_we` high stores `prog_base` as the base of window `prog_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Active-high reset; strap sampled while high |
| addr | input | 11 | Host I/O address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| aen | input | 1 | High during DMA cycles; blocks all selects |
| ext_cs_en | input | 1 | Makes cs_n part of every decode |
| cs_n | input | 1 | Active-low external chip select |
| strap | input | 1 | Index port base choice (0: 0x3F0, 1: 0x370) |
| prog_we | input | 1 | Window base write enable |
| prog_idx | input | 2 | Window number to write |
| prog_base | input | 11 | Base address to store |
| cfg_idx_sel | output | 1 | Configuration index port select |
| cfg_dat_sel | output | 1 | Configuration data port select |
| fn_sel | output | 4 | One-hot function window selects |
| addr_lat | output | 11 | Address held for the current cycle |

## Verification
A table of reads and writes is run at the first and last byte of each window, one byte past a window, an address that differs only in A10, and both configuration ports. These separate full-width decoding and window sizing from partial matches. The same addresses are repeated with DMA flagged and with the external select enabled and then deasserted, which separates each qualifier from the address compare. In every cycle the address is changed after the leading edge and the strobe is released, which shows the hold and the immediate drop. Directed cases cover overlapping windows, a window laid over the index port, a zero base, unaligned base bits, and two resets with different straps, where the programmed map must survive.

// File: rtl/hio_pkg.sv
package hio_pkg;
    localparam int ADDR_W = 11;

    typedef logic [ADDR_W-1:0] ioaddr_t;

    typedef struct packed {
        logic    act;
        ioaddr_t addr;
    } hold_t;

    typedef struct packed {
        logic alt;
    } strap_t;
endpackage

// File: rtl/hio_strobe_hold.sv
module hio_strobe_hold
    import hio_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_n,
    input  logic    wr_n,
    input  ioaddr_t addr,
    output logic    strb,
    output ioaddr_t addr_eff
);
    hold_t hold_d, hold_q;
    logic  lead;

    always_comb begin
        strb     = ~rd_n | ~wr_n;
        lead     = strb & ~hold_q.act;
        addr_eff = lead ? addr : hold_q.addr;
        hold_d.act  = strb;
        hold_d.addr = addr_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    // R1: once the strobe has been seen low, the held address does not move
    a_r1_addr_held: assert property (@(posedge clk) disable iff (rst)
        (strb && hold_q.act) |-> $stable(addr_eff));
endmodule

// File: rtl/hio_base_bank.sv
module hio_base_bank
    import hio_pkg::*;
#(
    parameter int NUM_FN = 4,
    localparam int IDX_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
)(
    input  logic                    clk,
    input  logic                    prog_we,
    input  logic [IDX_W-1:0]        prog_idx,
    input  ioaddr_t                 prog_base,
    output logic [NUM_FN-1:0][ADDR_W-1:0] bases
);
    logic [NUM_FN-1:0][ADDR_W-1:0] bases_d, bases_q;

    always_comb begin
        bases_d = bases_q;
        if (prog_we) bases_d[prog_idx] = prog_base;
    end

    // no reset branch: a programmed map survives reset (R6)
    always_ff @(posedge clk) begin
        bases_q <= bases_d;
    end

    assign bases = bases_q;
endmodule

// File: rtl/hio_win_match.sv
module hio_win_match
    import hio_pkg::*;
#(
    parameter int NUM_FN   = 4,
    parameter int WIN_LOG2 = 3
)(
    input  ioaddr_t                       addr,
    input  logic [NUM_FN-1:0][ADDR_W-1:0] bases,
    output logic [NUM_FN-1:0]             first_hit
);
    logic [NUM_FN-1:0] raw_hit;
    logic              found;

    for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
        assign raw_hit[i] = (bases[i] != '0) &&
            (addr[ADDR_W-1:WIN_LOG2] == bases[i][ADDR_W-1:WIN_LOG2]);
    end

    always_comb begin
        first_hit = '0;
        found     = 1'b0;
        for (int i = 0; i < NUM_FN; i++) begin
            if (raw_hit[i] && !found) begin
                first_hit[i] = 1'b1;
                found        = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hostio_decoder.sv
module hostio_decoder
    import hio_pkg::*;
#(
    parameter int      NUM_FN      = 4,
    parameter int      WIN_LOG2    = 3,
    parameter ioaddr_t CFG_BASE_LO = 11'h3F0,
    parameter ioaddr_t CFG_BASE_HI = 11'h370,
    localparam int     IDX_W       = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [10:0]       addr,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              aen,
    input  logic              ext_cs_en,
    input  logic              cs_n,
    input  logic              strap,
    input  logic              prog_we,
    input  logic [IDX_W-1:0]  prog_idx,
    input  logic [10:0]       prog_base,
    output logic              cfg_idx_sel,
    output logic              cfg_dat_sel,
    output logic [NUM_FN-1:0] fn_sel,
    output logic [10:0]       addr_lat
);
    strap_t  strap_d, strap_q;
    logic    strb, qual, idx_hit, dat_hit;
    ioaddr_t addr_eff, cfg_base;
    logic [NUM_FN-1:0][ADDR_W-1:0] bases;
    logic [NUM_FN-1:0]             win_hit;

    hio_strobe_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .addr     (addr),
        .strb     (strb),
        .addr_eff (addr_eff)
    );

    hio_base_bank #(.NUM_FN(NUM_FN)) u_bank (
        .clk       (clk),
        .prog_we   (prog_we),
        .prog_idx  (prog_idx),
        .prog_base (prog_base),
        .bases     (bases)
    );

    hio_win_match #(.NUM_FN(NUM_FN), .WIN_LOG2(WIN_LOG2)) u_match (
        .addr      (addr_eff),
        .bases     (bases),
        .first_hit (win_hit)
    );

    always_comb begin
        strap_d.alt = rst ? strap : strap_q.alt;
        cfg_base    = strap_q.alt ? CFG_BASE_HI : CFG_BASE_LO;
        idx_hit     = (addr_eff == cfg_base);
        dat_hit     = (addr_eff == cfg_base + ADDR_W'(1));
        qual        = strb & ~aen & ~rst & (~ext_cs_en | ~cs_n);
        cfg_idx_sel = qual & idx_hit;
        cfg_dat_sel = qual & dat_hit;
        fn_sel      = (qual & ~idx_hit & ~dat_hit) ? win_hit : '0;
        addr_lat    = addr_eff;
    end

    always_ff @(posedge clk) begin
        strap_q <= strap_d;
    end

    // R3: DMA cycles decode nothing
    a_r3_aen_quiet: assert property (@(posedge clk) disable iff (rst)
        aen |-> (!cfg_idx_sel && !cfg_dat_sel && fn_sel == '0));

    // R10: no select without an active strobe
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (rd_n && wr_n) |-> (!cfg_idx_sel && !cfg_dat_sel && fn_sel == '0));

    // R9: at most one select at a time
    a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cfg_idx_sel, cfg_dat_sel, fn_sel}));

    // R5: strap choice frozen once reset is released
    a_r5_strap_frozen: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_q.alt));

    for (genvar i = 0; i < NUM_FN; i++) begin : g_chk
        // R8: a zero base never selects
        a_r8_zero_base_off: assert property (@(posedge clk) disable iff (rst)
            fn_sel[i] |-> (bases[i] != '0));
    end
endmodule

// File: tb/hostio_decoder_tb.sv
module hostio_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] addr = '0;
    logic        rd_n = 1'b1, wr_n = 1'b1, aen = 1'b0;
    logic        ext_cs_en = 1'b0, cs_n = 1'b1, strap = 1'b1;
    logic        prog_we = 1'b0;
    logic [1:0]  prog_idx = '0;
    logic [10:0] prog_base = '0;
    logic        cfg_idx_sel, cfg_dat_sel;
    logic [3:0]  fn_sel;
    logic [10:0] addr_lat;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    hostio_decoder u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .aen(aen), .ext_cs_en(ext_cs_en), .cs_n(cs_n), .strap(strap),
        .prog_we(prog_we), .prog_idx(prog_idx), .prog_base(prog_base),
        .cfg_idx_sel(cfg_idx_sel), .cfg_dat_sel(cfg_dat_sel),
        .fn_sel(fn_sel), .addr_lat(addr_lat)
    );

    // fields: addr[20:10] wr[9] aen[8] ext[7] csn[6] exp[5:0]={idx,dat,fn3..fn0}
    localparam logic [20:0] VEC [16] = '{
        {11'h370, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100000},
        {11'h371, 1'b1, 1'b0, 1'b0, 1'b0, 6'b010000},
        {11'h2F8, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000001},
        {11'h2FF, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000001},
        {11'h300, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000},
        {11'h378, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000010},
        {11'h37F, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000010},
        {11'h678, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000100},
        {11'h278, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000},
        {11'h000, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000},
        {11'h2F8, 1'b0, 1'b1, 1'b0, 1'b0, 6'b000000},
        {11'h370, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000000},
        {11'h2F8, 1'b0, 1'b0, 1'b1, 1'b1, 6'b000000},
        {11'h2F8, 1'b0, 1'b0, 1'b1, 1'b0, 6'b000001},
        {11'h3F0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000},
        {11'h378, 1'b0, 1'b0, 1'b0, 1'b1, 6'b000010}
    };

    function automatic logic [5:0] sels();
        return {cfg_idx_sel, cfg_dat_sel, fn_sel};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic prog(input logic [1:0] idx, input logic [10:0] base);
        @(negedge clk);
        prog_we = 1'b1; prog_idx = idx; prog_base = base;
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic cycle(input logic [10:0] a, input logic wr, input logic dma,
                         input logic ext, input logic csn, input logic [5:0] exp,
                         input string req);
        @(negedge clk);
        addr = a; aen = dma; ext_cs_en = ext; cs_n = csn;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        #1 chk(req, 16'(sels()), 16'(exp));
        @(posedge clk);
        @(negedge clk);
        addr = 11'h7FF;
        #1 chk("R1 hold sel", 16'(sels()), 16'(exp));
        chk("R1 addr_lat", 16'(addr_lat), 16'(a));
        rd_n = 1'b1; wr_n = 1'b1;
        #1 chk("R10 drop", 16'(sels()), 16'h0);
        aen = 1'b0; ext_cs_en = 1'b0; cs_n = 1'b1;
    endtask

    initial begin
        // program bases while in reset (R11): fn0 0x2F8, fn1 0x378, fn2 0x678, fn3 off
        prog(2'd0, 11'h2F8);
        prog(2'd1, 11'h378);
        prog(2'd2, 11'h678);
        prog(2'd3, 11'h000);
        @(negedge clk);
        addr = 11'h370; rd_n = 1'b0;
        #1 chk("R10 in reset", 16'(sels()), 16'h0);
        rd_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        strap = 1'b0;   // R5: ignored after release
        #1 chk("R10 reset state", 16'(sels()), 16'h0);

        for (int i = 0; i < 16; i++) begin
            string t;
            t = VEC[i][8] ? "R3 dma" : (VEC[i][7] || VEC[i][6]) ? "R4 ext cs" : "R2 decode";
            cycle(VEC[i][20:10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:0], t);
        end

        cycle(11'h371, 1'b0, 1'b0, 1'b0, 1'b0, 6'b010000, "R7 data port");
        cycle(11'h370, 1'b1, 1'b0, 1'b0, 1'b0, 6'b100000, "R5 strap kept");
        cycle(11'h005, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000000, "R8 zero base");
        prog(2'd2, 11'h67D);
        cycle(11'h67A, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000100, "R11 low bits ignored");
        prog(2'd3, 11'h378);
        cycle(11'h37C, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000010, "R9 lowest window wins");
        prog(2'd3, 11'h370);
        cycle(11'h370, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100000, "R9 cfg over window");

        // second reset with strap 0
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        strap = 1'b1;
        cycle(11'h3F0, 1'b0, 1'b0, 1'b0, 1'b0, 6'b100000, "R5 strap0 index");
        cycle(11'h3F1, 1'b1, 1'b0, 1'b0, 1'b0, 6'b010000, "R5 strap0 data");
        cycle(11'h370, 1'b0, 1'b0, 1'b0, 1'b0, 6'b001000, "R6 fn3 kept");
        cycle(11'h2F8, 1'b0, 1'b0, 1'b0, 1'b0, 6'b000001, "R6 fn0 kept");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule